// File: doc/BRIEF.md
# Bit-Slice Spiking Neuron Array

This block is an array of N leaky integrate-and-fire neurons, built from identical slices with one neuron in each slice. Each slice keeps its own membrane potential and a full column of incoming synaptic weights, one weight for every possible source neuron. Because of this, any connection topology can be loaded, and an absent synapse is simply a zero weight. After reset all weights and potentials are zero. Weights and initial potentials are loaded while the array is idle.

A pulse on `step` runs one time step. In the first cycle every potential decays by a fixed leak. In the second cycle every neuron at or above threshold fires. Its bit is set in the spike vector and its potential is set to the reset value. Every spike of that step then forms one batch. The batch is propagated one source per cycle, lowest index first, and every slice adds its weight for that source. A quiet step therefore costs three cycles, and a step with k spikes costs 3+k cycles, whatever the network size. All arithmetic saturates.

Top module: `snn_array`

## Requirements
- R1: While reset is held and in the first cycle after it, every potential is 0, `spikes` is all zero, and `busy`, `done` and `any_spike` are low. Every stored weight is 0.
- R2: In an idle cycle, a high `wt_we` stores `wt_data` as the weight from source `wt_src` into destination neuron `wt_dst`. When the array is busy, `wt_we` has no effect.
- R3: In an idle cycle, a high `pot_we` sets the potential of neuron `pot_idx` to `pot_data`. When the array is busy, `pot_we` is ignored, and the potentials that result are unchanged by it.
- R4: The cycle after `step` is accepted, every potential becomes its value minus LEAK. The result saturates at the most negative value of the PW-bit signed range.
- R5: In the cycle after the leak, every neuron whose potential is at least THRESH fires. The bit at its index in `spikes` is 1, and its potential becomes RESET_V. `spikes` then holds this value until the fire cycle of the next step.
- R6: `any_spike` is high exactly when at least one bit of `spikes` is set.
- R7: Each firing neuron is delivered once, one source per cycle in ascending index order. In that cycle every neuron i adds its weight from that source to its potential. A neuron that fires changes its own potential only through its own self-weight.
- R8: Each addition during propagation saturates to the PW-bit signed range. It never wraps.
- R9: `done` is high for exactly one cycle per step. With k neurons firing, it is seen 3+k cycles after the cycle in which `step` was driven. `busy` is high from the leak cycle through the `done` cycle.
- R10: A `step` pulse given while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wt_we | input | 1 | Weight write strobe |
| wt_dst | input | IW | Destination neuron of the weight |
| wt_src | input | IW | Source neuron of the weight |
| wt_data | input | WW | Signed weight value |
| pot_we | input | 1 | Potential initialisation strobe |
| pot_idx | input | IW | Neuron whose potential is loaded |
| pot_data | input | PW | Signed initial potential |
| step | input | 1 | Start one time step |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle step-complete pulse |
| spikes | output | N | Fire flags of the last fire phase |
| any_spike | output | 1 | OR of the fire flags |
| potentials | output | N*PW | Membrane potentials, neuron i at bits i*PW upward |

## Verification
The bench builds the array with N=6, PW=8, WW=8, LEAK=3, THRESH=50 and RESET_V=-10. The 8-bit potential range lets a single step with large weights reach saturation in both directions, and it lets a potential already at the minimum be pushed further down by the leak. Six neurons keep the batch lengths short, so a step with two spikes, a step with one spike and a quiet step can be timed by hand. A behavioural model then follows a series of further steps on a loaded dense weight set.

// File: rtl/snn_pkg.sv
package snn_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAK,
        PH_FIRE,
        PH_PROP,
        PH_DONE
    } phase_e;

    typedef enum logic [2:0] {
        SOP_HOLD,
        SOP_LOAD,
        SOP_LEAK,
        SOP_FIRE,
        SOP_ADD
    } slice_op_e;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/snn_slice.sv
module snn_slice
    import snn_pkg::*;
#(
    parameter int N       = 8,
    parameter int PW      = 12,
    parameter int WW      = 10,
    parameter int IW      = 3,
    parameter int LEAK    = 2,
    parameter int THRESH  = 100,
    parameter int RESET_V = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  slice_op_e            op,
    input  logic                 wt_we,
    input  logic [IW-1:0]        wt_src,
    input  logic signed [WW-1:0] wt_data,
    input  logic signed [PW-1:0] pot_data,
    input  logic [IW-1:0]        add_src,
    output logic signed [PW-1:0] pot,
    output logic                 fire
);

    localparam int MAXV = 2 ** (PW - 1) - 1;
    localparam int MINV = -(2 ** (PW - 1));

    logic signed [WW-1:0] wmem [N];

    function automatic logic signed [PW-1:0] clamp(input int v);
        int r;
        r = (v > MAXV) ? MAXV : ((v < MINV) ? MINV : v);
        return r[PW-1:0];
    endfunction

    assign fire = (int'(pot) >= THRESH);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < N; j++) wmem[j] <= '0;
        end else if (wt_we) begin
            wmem[wt_src] <= wt_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pot <= '0;
        end else begin
            unique case (op)
                SOP_LOAD: pot <= pot_data;
                SOP_LEAK: pot <= clamp(int'(pot) - LEAK);
                SOP_FIRE: if (fire) pot <= clamp(RESET_V);
                SOP_ADD:  pot <= clamp(int'(pot) + int'(wmem[add_src]));
                default:  pot <= pot;
            endcase
        end
    end

endmodule

// File: rtl/snn_lowest_set.sv
module snn_lowest_set #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    assign any = |vec;

endmodule

// File: rtl/snn_array.sv
module snn_array
    import snn_pkg::*;
#(
    parameter int N       = 8,
    parameter int PW      = 12,
    parameter int WW      = 10,
    parameter int LEAK    = 2,
    parameter int THRESH  = 100,
    parameter int RESET_V = 0,
    localparam int IW     = snn_pkg::idx_w(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wt_we,
    input  logic [IW-1:0]     wt_dst,
    input  logic [IW-1:0]     wt_src,
    input  logic [WW-1:0]     wt_data,
    input  logic              pot_we,
    input  logic [IW-1:0]     pot_idx,
    input  logic [PW-1:0]     pot_data,
    input  logic              step,
    output logic              busy,
    output logic              done,
    output logic [N-1:0]      spikes,
    output logic              any_spike,
    output logic [N*PW-1:0]   potentials
);

    phase_e        phase;
    logic [N-1:0]  fire_vec;
    logic [N-1:0]  pend;
    logic [N-1:0]  clr_mask;
    logic [IW-1:0] src;
    logic          pend_any;
    logic          fire_any;
    logic          idle;

    assign idle     = (phase == PH_IDLE);
    assign fire_any = |fire_vec;

    snn_lowest_set #(.N(N), .IW(IW)) u_pick (
        .vec (pend),
        .idx (src),
        .any (pend_any)
    );

    always_comb begin
        clr_mask      = '0;
        clr_mask[src] = 1'b1;
    end

    for (genvar i = 0; i < N; i++) begin : g_slice
        slice_op_e            op_i;
        logic signed [PW-1:0] pot_i;

        always_comb begin
            unique case (phase)
                PH_IDLE: op_i = (pot_we && pot_idx == IW'(i)) ? SOP_LOAD : SOP_HOLD;
                PH_LEAK: op_i = SOP_LEAK;
                PH_FIRE: op_i = SOP_FIRE;
                PH_PROP: op_i = pend_any ? SOP_ADD : SOP_HOLD;
                default: op_i = SOP_HOLD;
            endcase
        end

        snn_slice #(
            .N(N), .PW(PW), .WW(WW), .IW(IW),
            .LEAK(LEAK), .THRESH(THRESH), .RESET_V(RESET_V)
        ) u_slice (
            .clk      (clk),
            .rst      (rst),
            .op       (op_i),
            .wt_we    (idle && wt_we && wt_dst == IW'(i)),
            .wt_src   (wt_src),
            .wt_data  (wt_data),
            .pot_data (pot_data),
            .add_src  (src),
            .pot      (pot_i),
            .fire     (fire_vec[i])
        );

        assign potentials[i*PW +: PW] = pot_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            pend      <= '0;
            spikes    <= '0;
            any_spike <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: if (step) phase <= PH_LEAK;
                PH_LEAK: phase <= PH_FIRE;
                PH_FIRE: begin
                    spikes    <= fire_vec;
                    any_spike <= fire_any;
                    pend      <= fire_vec;
                    phase     <= fire_any ? PH_PROP : PH_DONE;
                end
                PH_PROP: begin
                    pend <= pend & ~clr_mask;
                    if ((pend & ~clr_mask) == '0) phase <= PH_DONE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy = !idle;
    assign done = (phase == PH_DONE);

endmodule

// File: rtl/snn_array_chk.sv
module snn_array_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         step,
    input logic         busy,
    input logic         done,
    input logic [N-1:0] spikes,
    input logic         any_spike
);

    // R6
    any_spike_or_chk: assert property (@(posedge clk) disable iff (rst)
        any_spike == (|spikes));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(step));

    // R5
    spikes_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(spikes));

endmodule

bind snn_array snn_array_chk #(.N(N)) u_snn_array_chk (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .busy      (busy),
    .done      (done),
    .spikes    (spikes),
    .any_spike (any_spike)
);

// File: tb/test_snn_array.sv
module test_snn_array;

    localparam int N    = 6;
    localparam int PW   = 8;
    localparam int WW   = 8;
    localparam int LK   = 3;
    localparam int TH   = 50;
    localparam int RV   = -10;
    localparam int IW   = 3;
    localparam int MAXV = 127;
    localparam int MINV = -128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wt_we = 1'b0, pot_we = 1'b0, step = 1'b0;
    logic [IW-1:0] wt_dst = '0, wt_src = '0, pot_idx = '0;
    logic [WW-1:0] wt_data = '0;
    logic [PW-1:0] pot_data = '0;
    logic busy, done, any_spike;
    logic [N-1:0] spikes;
    logic [N*PW-1:0] potentials;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    snn_array #(.N(N), .PW(PW), .WW(WW), .LEAK(LK), .THRESH(TH), .RESET_V(RV)) i_snn_array (
        .clk(clk), .rst(rst), .wt_we(wt_we), .wt_dst(wt_dst), .wt_src(wt_src),
        .wt_data(wt_data), .pot_we(pot_we), .pot_idx(pot_idx), .pot_data(pot_data),
        .step(step), .busy(busy), .done(done), .spikes(spikes),
        .any_spike(any_spike), .potentials(potentials)
    );

    // behavioural reference
    int m_ph;   // 0 idle 1 leak 2 fire 3 prop 4 done
    int m_pot [N];
    int m_w [N][N];
    bit [N-1:0] m_spk;
    bit m_any;
    int q [$];

    function automatic int sat(input int v);
        return (v > MAXV) ? MAXV : ((v < MINV) ? MINV : v);
    endfunction

    function automatic int pot_of(input int i);
        logic signed [PW-1:0] p;
        p = potentials[i*PW +: PW];
        return int'(p);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_spk = '0; m_any = 0; q.delete();
            for (int i = 0; i < N; i++) begin
                m_pot[i] = 0;
                for (int j = 0; j < N; j++) m_w[i][j] = 0;
            end
        end else begin
            case (m_ph)
                0: begin
                    if (wt_we) m_w[wt_dst][wt_src] = int'($signed(wt_data));
                    if (pot_we) m_pot[pot_idx] = int'($signed(pot_data));
                    if (step) m_ph = 1;
                end
                1: begin
                    for (int i = 0; i < N; i++) m_pot[i] = sat(m_pot[i] - LK);
                    m_ph = 2;
                end
                2: begin
                    q.delete(); m_spk = '0;
                    for (int i = 0; i < N; i++)
                        if (m_pot[i] >= TH) begin m_spk[i] = 1; m_pot[i] = RV; q.push_back(i); end
                    m_any = (q.size() > 0);
                    m_ph = m_any ? 3 : 4;
                end
                3: begin
                    int s;
                    s = q.pop_front();
                    for (int i = 0; i < N; i++) m_pot[i] = sat(m_pot[i] + m_w[i][s]);
                    m_ph = (q.size() > 0) ? 3 : 4;
                end
                default: m_ph = 0;
            endcase
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R9 busy", int'(busy), int'(m_ph != 0));
            chk("R9 done", int'(done), int'(m_ph == 4));
            chk("R5 spikes", int'(spikes), int'(m_spk));
            chk("R6 any_spike", int'(any_spike), int'(m_any));
            for (int i = 0; i < N; i++)
                chk($sformatf("R3/R4/R7/R8 pot%0d", i), pot_of(i), m_pot[i]);
        end
    end

    task automatic put_w(input int dst, input int src, input int val);
        @(negedge clk);
        wt_we = 1; wt_dst = IW'(dst); wt_src = IW'(src); wt_data = WW'(val);
        @(negedge clk);
        wt_we = 0;
    endtask

    task automatic put_p(input int idx, input int val);
        @(negedge clk);
        pot_we = 1; pot_idx = IW'(idx); pot_data = PW'(val);
        @(negedge clk);
        pot_we = 0;
    endtask

    // runs one step; optionally pokes step and pot_we while busy
    task automatic run_step(input bit poke, output int cyc);
        @(negedge clk);
        step = 1;
        @(negedge clk);
        step = 0;
        cyc = 1;
        while (!done && cyc < 100) begin
            if (poke && cyc == 2) begin
                step = 1; pot_we = 1; pot_idx = 3'd1; pot_data = PW'(90);
            end
            @(negedge clk);
            step = 0; pot_we = 0;
            cyc++;
        end
    endtask

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        // R1
        chk("R1 busy", int'(busy), 0);
        chk("R1 spikes", int'(spikes), 0);
        chk("R1 pot0", pot_of(0), 0);
        rst = 0;
        @(negedge clk);
        chk("R1 done", int'(done), 0);
        chk("R1 any_spike", int'(any_spike), 0);

        // R2 weights, R3 potentials
        put_w(1, 0, 40);  put_w(2, 0, 100); put_w(2, 3, 100);
        put_w(0, 0, 5);   put_w(4, 0, -128); put_w(4, 3, -128);
        put_p(0, 60); put_p(3, 53); put_p(4, -100);
        chk("R3 pot3 loaded", pot_of(3), 53);

        run_step(0, cyc);
        chk("R9 latency k=2", cyc, 5);
        chk("R5 spike vector", int'(spikes), 6'b001001);
        chk("R6 any_spike set", int'(any_spike), 1);
        chk("R7 self-weight pot0", pot_of(0), -5);
        chk("R7 pot1", pot_of(1), 37);
        chk("R2 pot2 weight from 0", pot_of(2) >= 97 ? 1 : 0, 1);
        chk("R8 pot2 upper sat", pot_of(2), 127);
        chk("R8 pot4 lower sat", pot_of(4), -128);
        chk("R5 pot3 reset value", pot_of(3), -10);
        chk("R4 pot5 leak", pot_of(5), -3);

        // R10 step and R3 pot_we during busy are ignored
        run_step(1, cyc);
        chk("R10 latency k=1", cyc, 4);
        chk("R5 spike vector 2", int'(spikes), 6'b000100);
        chk("R3 pot1 not loaded while busy", pot_of(1), 34);
        chk("R4 pot4 leak saturates", pot_of(4), -128);
        @(negedge clk);
        chk("R10 idle after ignored step", int'(busy), 0);

        // quiet step
        run_step(0, cyc);
        chk("R9 latency k=0", cyc, 3);
        chk("R6 any_spike clear", int'(any_spike), 0);

        // dense weights and repeated steps against the model
        for (int d = 0; d < N; d++)
            for (int s = 0; s < N; s++)
                put_w(d, s, ((d * 7 + s * 13) % 41) - 8);
        for (int i = 0; i < N; i++) put_p(i, 30 + i * 9);
        for (int k = 0; k < 25; k++) run_step(0, cyc);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL R9 watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule